// File: doc/BRIEF.md
# Channel Batch Sample Transposer

This block turns a channel-major stream of capture words into time-major sample words. Each 32-bit input word carries 32 consecutive samples of a single enabled digital channel. The earliest sample is in the top bit. One word arrives for every enabled channel, lowest channel index first, and together these words make up a batch. After the last word of a batch has been taken, the block plays out 32 words of 16 bits. Word k holds the level of every enabled channel at sample time k, each in its own channel bit position.

A 16-bit enable mask chooses the channels. The mask is taken in only between batches, so a change made while a batch is being gathered or played out has no effect until the block is idle again. Input words use a valid/ready handshake, and so do output words. While a finished batch is being played out, no new input word is accepted. A batch that is half gathered survives any pause in the input stream.

Top module: `batch_transposer`

## Requirements
- R1: Output word k of a batch (k = 0..31, k = 0 played first) takes its bits from input bit position 31-k, so bit 31 of each input word is the earliest sample.
- R2: The n-th input word of a batch (n counted from 0) belongs to the n-th lowest set bit of the enable mask. Its samples land only in that channel's output bit.
- R3: Output bits of channels whose enable bit is 0 are always 0. A bit of an enabled channel is 1 exactly when that channel's word had the matching sample bit set.
- R4: The first word of a batch overwrites the stored samples, so nothing from an earlier batch appears in later output.
- R5: out_valid stays 0 until the word of the highest enabled channel has been accepted. The batch then plays out as exactly 32 words, and out_last is 1 on the 32nd of them only.
- R6: Gaps in in_valid in the middle of a batch do not lose or reorder the words already accepted.
- R7: cfg_mask is sampled only while no batch is being gathered or played out. A change made after the first word of a batch does not alter that batch.
- R8: When the sampled mask is all zero, in_ready stays 0 and no output word is produced.
- R9: While a batch plays out, in_ready is 0. While out_valid is 1 and out_ready is 0, out_word and out_last hold their values.
- R10: After reset, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mask | input | 16 | Channel enable mask, bit c enables channel c |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted on this edge when in_valid is 1 |
| in_word | input | 32 | 32 samples of one channel, bit 31 earliest |
| out_valid | output | 1 | Output sample word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | 16 | One sample time across all channels |
| out_last | output | 1 | Marks the 32nd output word of a batch |

## Verification
Two events meet in a single cycle. In one case the first word of a batch is accepted in the same cycle that the mask register would otherwise reload from cfg_mask. In the other, the final output handshake of a batch lands while the next input word is already waiting. The bench changes cfg_mask right after a first word is taken and expects the batch to follow the old mask. It also keeps in_valid high all through the play-out, against a stalling out_ready. It requires in_ready to stay 0 until the 32nd word has gone and out_word to hold during every stall.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int NCHAN_DEF = 16;
    localparam int NSAMP_DEF = 32;
endpackage

// File: rtl/tp_lowbit.sv
module tp_lowbit #(
    parameter int W = 16
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] pick
);
    // seen[i] is high when any bit below i is set
    logic [W-1:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pick[i] = vec[i] & ~seen[i];
        if (i < W - 1) begin : g_chain
            assign seen[i+1] = seen[i] | vec[i];
        end
    end
endmodule

// File: rtl/tp_store.sv
module tp_store #(
    parameter int NCHAN = 16,
    parameter int NSAMP = 32,
    localparam int IW = $clog2(NSAMP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             clr,
    input  logic [NCHAN-1:0] sel,
    input  logic [NSAMP-1:0] word,
    input  logic [IW-1:0]    rd_idx,
    output logic [NCHAN-1:0] rd_data
);
    logic [NCHAN-1:0] lane_d [NSAMP];
    logic [NCHAN-1:0] lane_q [NSAMP];

    // one lane per sample time; sample k comes from word bit NSAMP-1-k
    for (genvar k = 0; k < NSAMP; k++) begin : g_lane
        always_comb begin
            lane_d[k] = lane_q[k];
            if (wr_en) begin
                lane_d[k] = (clr ? '0 : lane_q[k]) | (word[NSAMP-1-k] ? sel : '0);
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) lane_q[k] <= '0;
            else        lane_q[k] <= lane_d[k];
        end
    end

    assign rd_data = lane_q[rd_idx];
endmodule

// File: rtl/batch_transposer.sv
module batch_transposer #(
    parameter int NCHAN = tp_pkg::NCHAN_DEF,
    parameter int NSAMP = tp_pkg::NSAMP_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCHAN-1:0] cfg_mask,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NSAMP-1:0] in_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [NCHAN-1:0] out_word,
    output logic             out_last
);
    localparam int IW = $clog2(NSAMP);
    localparam logic [IW-1:0] LAST_IDX = IW'(NSAMP - 1);

    typedef struct packed {
        logic [NCHAN-1:0] mask;
        logic [NCHAN-1:0] rem;
        logic             busy;
        logic             drain;
        logic [IW-1:0]    idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NCHAN-1:0] cur;
    logic [NCHAN-1:0] rem_next;
    logic idle, take, give;

    tp_lowbit #(.W(NCHAN)) u_pick (
        .vec  (ctl_q.rem),
        .pick (cur)
    );

    assign idle     = !ctl_q.busy && !ctl_q.drain;
    assign in_ready = !ctl_q.drain && (ctl_q.busy || (ctl_q.mask != '0));
    assign take     = in_valid && in_ready;
    assign give     = ctl_q.drain && out_ready;
    assign rem_next = ctl_q.rem & ~cur;

    always_comb begin
        ctl_d = ctl_q;
        if (idle && !take) begin
            ctl_d.mask = cfg_mask;
            ctl_d.rem  = cfg_mask;
        end
        if (take) begin
            ctl_d.rem = rem_next;
            if (rem_next == '0) begin
                ctl_d.busy  = 1'b0;
                ctl_d.drain = 1'b1;
                ctl_d.idx   = '0;
            end else begin
                ctl_d.busy = 1'b1;
            end
        end
        if (give) begin
            ctl_d.idx = ctl_q.idx + 1'b1;
            if (ctl_q.idx == LAST_IDX) begin
                ctl_d.drain = 1'b0;
                ctl_d.rem   = ctl_q.mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    tp_store #(.NCHAN(NCHAN), .NSAMP(NSAMP)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take),
        .clr     (!ctl_q.busy),
        .sel     (cur),
        .word    (in_word),
        .rd_idx  (ctl_q.idx),
        .rd_data (out_word)
    );

    assign out_valid = ctl_q.drain;
    assign out_last  = ctl_q.drain && (ctl_q.idx == LAST_IDX);

    AST_PICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($countones(cur) == 1)); // R2
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_word & ~ctl_q.mask) == '0)); // R3
    AST_RELEASE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(take)); // R5
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy || ctl_q.drain) |=> $stable(ctl_q.mask)); // R7
    AST_ZERO_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && ctl_q.mask == '0) |-> !in_ready); // R8
    AST_STALL_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last))); // R9
endmodule

// File: tb/sim_batch_transposer.sv
module sim_batch_transposer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_mask = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_word;
    logic        out_last;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] wq [16];

    always #2 clk = ~clk;

    batch_transposer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [15:0] m, input int k);
        logic [15:0] r = '0;
        int n = 0;
        for (int c = 0; c < 16; c++) begin
            if (m[c]) begin
                if (wq[n][31-k]) r[c] = 1'b1;
                n++;
            end
        end
        return r;
    endfunction

    task automatic set_mask(input logic [15:0] m);
        cfg_mask = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // mode 0: always ready; mode 1: stall every third cycle
    task automatic drain_check(input logic [15:0] m, input int mode, input string tag);
        int k = 0;
        int cyc = 0;
        bit stalled = 0;
        logic [15:0] held = '0;
        while (k < 32 && cyc < 400) begin
            out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (stalled) chk(out_word == held, "R9 hold", {16'h0, out_word}, {16'h0, held});
            stalled = 0;
            if (out_valid) begin
                if (in_valid) chk(!in_ready, "R9 in_ready", {31'h0, in_ready}, 32'h0);
                if (out_ready) begin
                    chk(out_word == model(m, k), tag, {16'h0, out_word}, {16'h0, model(m, k)});
                    chk(out_last == (k == 31), "R5 last", {31'h0, out_last}, {31'h0, k == 31});
                    k++;
                end else begin
                    stalled = 1;
                    held = out_word;
                end
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        chk(k == 32, "R5 count", k, 32);
        chk(!out_valid, "R5 end", {31'h0, out_valid}, 32'h0);
    endtask

    task automatic send_batch(input logic [15:0] m);
        int n = $countones(m);
        for (int i = 0; i < n; i++) begin
            push(wq[i]);
            if (i < n - 1) chk(!out_valid, "R5 early", {31'h0, out_valid}, 32'h0);
        end
    endtask

    task automatic t_reset;
        chk(!out_valid, "R10 reset", {31'h0, out_valid}, 32'h0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 16; i++) wq[i] = 32'hA5C3_0000 ^ (32'h0102_0409 * (i + 1));
        set_mask(16'hFFFF);
        send_batch(16'hFFFF);
        drain_check(16'hFFFF, 0, "R1 R2 full");
    endtask

    task automatic t_sparse;
        for (int i = 0; i < 16; i++) wq[i] = 32'h8000_0001 << i | 32'h0F00_F0F0;
        set_mask(16'h8421);
        send_batch(16'h8421);
        drain_check(16'h8421, 0, "R3 sparse");
    endtask

    task automatic t_clear;
        for (int i = 0; i < 16; i++) wq[i] = 32'hFFFF_FFFF;
        set_mask(16'h0003);
        send_batch(16'h0003);
        drain_check(16'h0003, 0, "R4 first");
        wq[0] = 32'h0000_000F;
        wq[1] = 32'h8000_0000;
        send_batch(16'h0003);
        drain_check(16'h0003, 0, "R4 cleared");
    endtask

    task automatic t_gap;
        for (int i = 0; i < 4; i++) wq[i] = 32'h1357_9BDF >> i;
        set_mask(16'h00F0);
        for (int i = 0; i < 4; i++) begin
            push(wq[i]);
            if (i < 3) begin
                repeat (3) @(negedge clk);
                chk(!out_valid, "R6 gap", {31'h0, out_valid}, 32'h0);
            end
        end
        drain_check(16'h00F0, 0, "R6 gapped");
    endtask

    task automatic t_mask_change;
        wq[0] = 32'hF0F0_1234;
        wq[1] = 32'h0FF0_8001;
        set_mask(16'h0005);
        push(wq[0]);
        cfg_mask = 16'hFFFF;
        @(negedge clk);
        push(wq[1]);
        drain_check(16'h0005, 0, "R7 old mask");
    endtask

    task automatic t_zero;
        set_mask(16'h0000);
        in_valid = 1'b1;
        in_word  = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        chk(!in_ready, "R8 ready", {31'h0, in_ready}, 32'h0);
        chk(!out_valid, "R8 output", {31'h0, out_valid}, 32'h0);
        in_valid = 1'b0;
    endtask

    task automatic t_backpressure;
        for (int i = 0; i < 8; i++) wq[i] = 32'h6B2D_91E4 ^ (32'h1111_1111 * i);
        set_mask(16'h0F0F);
        send_batch(16'h0F0F);
        in_valid = 1'b1;
        in_word  = 32'h0;
        drain_check(16'h0F0F, 1, "R9 stalled");
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_sparse();
        t_clear();
        t_gap();
        t_mask_change();
        t_zero();
        t_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule